// File: doc/BRIEF.md
# Infrared Link Mode Staging with Low-Speed Pulse Shaper

This block keeps the configuration of an infrared serial link. Software writes a mode word (low, medium or high-speed mode, short CRC, line polarities, transmit and receive enables, loopback) and a physical-layer control word into staging registers. The staged mode and physical-layer settings stay dormant until the link enable input rises. On that edge they are copied into the applied registers, and the block reports them in a read-only status word.

When the applied mode is the low-speed mode and the link is enabled, the block turns a serial transmit bit stream into narrow optical pulses. Each zero bit gives one pulse at the start of its bit cell and each one bit gives none. The applied divider field sets the length of the bit cell. The width field, scaled by the divider, sets the length of the pulse. The receive line passes through an applied polarity inverter. Encoders for the faster modes, CRC logic and the transceiver itself sit outside this block.

Top module: `ir_phy_stager`

## Requirements
- R1: Writes to the staging registers change neither `phy_act` nor the applied mode, polarity and CRC status while the enable stays steady. On the clock edge where `phy_en` is first seen high after being low, the staged values that were held before that edge become the applied values, visible after that edge.
- R2: `phy_act` reads back the applied physical-layer word, laid out as divider in [15:10], pulse width in [9:5] and preamble in [4:0].
- R3: If more than one of the mode bits (`cfg_wdata` bit 0 low-speed, bit 1 medium-speed, bit 2 high-speed) was applied, status bit 14 reads 1 and status bits [13:11] read 0. No pulses or bit requests are produced.
- R4: The status word carries these bits: [15] enable seen, [14] error, [13] high-speed on, [12] medium-speed on, [11] low-speed on, [10] transmit-enable state, [9] receive-enable state, [8] short CRC on (`cfg_wdata` bit 3). Bits [7:0] read 0. The mode-on bits and bit 8 read 0 while bit 15 is 0.
- R5: Status bit 10 follows staged transmit enable (`cfg_wdata` bit 6) and bit 9 equals staged receive enable (bit 7) AND (NOT transmit enable OR loopback (bit 8)). Both follow a write one cycle later, whatever the enable.
- R6: In applied low-speed mode, a zero bit taken at a cell start drives the pulse active for (W+1)*(D+1) `unit_tick` pulses, starting in the cycle after the take. W is the width field and D is the divider field. A one bit drives no pulse.
- R7: A bit cell spans 16*(D+1) `ref_tick` pulses. `tx_take` is high in exactly the `ref_tick` cycle that starts each cell, and `tx_bit` is sampled in that cycle.
- R8: `ir_tx` is 0 whenever status bit 15 is 0. Otherwise it is the pulse state XOR the applied transmit inversion (`cfg_wdata` bit 4).
- R9: `rx_data` equals `ir_rx` XOR the applied receive inversion (`cfg_wdata` bit 5).
- R10: After synchronous reset all status bits, `phy_act`, `ir_tx`, `tx_take` and the applied settings are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the staged mode word |
| cfg_wdata | input | 9 | Staged mode word |
| phy_we | input | 1 | Write strobe for the staged physical-layer word |
| phy_wdata | input | 16 | Staged physical-layer word |
| phy_en | input | 1 | Link enable; rising edge applies staged settings |
| ref_tick | input | 1 | Reference enable at 16 times the top low-speed rate |
| unit_tick | input | 1 | Pulse-width unit enable |
| tx_bit | input | 1 | Serial transmit bit, sampled when `tx_take` is high |
| tx_take | output | 1 | Cell start: `tx_bit` consumed this cycle |
| ir_tx | output | 1 | Optical transmit drive |
| ir_rx | input | 1 | Optical receive line |
| rx_data | output | 1 | Polarity-corrected receive data |
| status | output | 16 | Applied-state status word |
| phy_act | output | 16 | Applied physical-layer word |

## Verification
A wrong applied register appears on `status` or `phy_act` in the cycle right after the enable edge, and a staged write that leaks through appears one cycle after the write. A wrong cell counter moves `tx_take` away from its expected `ref_tick` within one cell. A wrong pulse counter stretches or clips `ir_tx` at the end of the first zero bit. A cycle-by-cycle model compares every output on every clock, so each such slip is reported in the cycle it first appears.

// File: rtl/irst_pkg.sv
package irst_pkg;

    localparam int STAT_W = 16;

    // Staged mode word, bit 0 at the right.
    typedef struct packed {
        logic loop;
        logic rx_en;
        logic tx_en;
        logic rx_inv;
        logic tx_inv;
        logic crc16;
        logic fir;
        logic mir;
        logic sir;
    } ir_cfg_t;

    localparam int CFG_W = $bits(ir_cfg_t);

    // Settings latched on the enable edge.
    typedef struct packed {
        logic sir;
        logic mir;
        logic fir;
        logic crc16;
        logic tx_inv;
        logic rx_inv;
        logic err;
    } ir_applied_t;

    function automatic logic mode_clash(input ir_cfg_t c);
        return (c.sir & c.mir) | (c.sir & c.fir) | (c.mir & c.fir);
    endfunction

    function automatic ir_applied_t latch_cfg(input ir_cfg_t c);
        ir_applied_t a;
        a.sir    = c.sir;
        a.mir    = c.mir;
        a.fir    = c.fir;
        a.crc16  = c.crc16;
        a.tx_inv = c.tx_inv;
        a.rx_inv = c.rx_inv;
        a.err    = mode_clash(c);
        return a;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input logic en,
                                                      input ir_applied_t a,
                                                      input ir_cfg_t live);
        logic on;
        on = en & ~a.err;
        return {en, a.err, on & a.fir, on & a.mir, on & a.sir,
                live.tx_en, live.rx_en & (~live.tx_en | live.loop),
                en & a.crc16, 8'h00};
    endfunction

endpackage

// File: rtl/ir_cfg_stage.sv
module ir_cfg_stage
    import irst_pkg::*;
#(
    parameter int PHY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  ir_cfg_t          cfg_d,
    input  logic             phy_we,
    input  logic [PHY_W-1:0] phy_d,
    input  logic             phy_en,
    output logic             en_q,
    output ir_applied_t      act,
    output logic [PHY_W-1:0] act_phy,
    output ir_cfg_t          live_cfg
);

    ir_cfg_t          stg_cfg;
    logic [PHY_W-1:0] stg_phy;
    logic             apply;

    assign apply    = phy_en & ~en_q;
    assign live_cfg = stg_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_cfg <= '0;
            stg_phy <= '0;
        end else begin
            if (cfg_we) stg_cfg <= cfg_d;
            if (phy_we) stg_phy <= phy_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            act     <= '0;
            act_phy <= '0;
        end else begin
            en_q <= phy_en;
            if (apply) begin
                act     <= latch_cfg(stg_cfg);
                act_phy <= stg_phy;
            end
        end
    end

endmodule

// File: rtl/ir_sir_shaper.sv
module ir_sir_shaper #(
    parameter int BAUD_W   = 6,
    parameter int WID_W    = 5,
    parameter int CELL_SUB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              ref_tick,
    input  logic              unit_tick,
    input  logic [BAUD_W-1:0] baud,
    input  logic [WID_W-1:0]  width,
    input  logic              tx_bit,
    output logic              tx_take,
    output logic              pulse_on
);

    localparam int CELL_W  = $clog2(CELL_SUB) + BAUD_W;
    localparam int PULSE_W = WID_W + BAUD_W + 1;

    logic [BAUD_W:0]    baud_p1;
    logic [WID_W:0]     wid_p1;
    logic [PULSE_W-1:0] pulse_len;
    logic [CELL_W:0]    cell_full;
    logic [CELL_W-1:0]  cell_last;
    logic [CELL_W-1:0]  cell_cnt;
    logic [PULSE_W-1:0] pulse_cnt;

    assign baud_p1   = (BAUD_W+1)'(baud) + (BAUD_W+1)'(1);
    assign wid_p1    = (WID_W+1)'(width) + (WID_W+1)'(1);
    assign pulse_len = PULSE_W'(wid_p1) * PULSE_W'(baud_p1);
    assign cell_full = (CELL_W+1)'(baud_p1) * (CELL_W+1)'(CELL_SUB);
    assign cell_last = CELL_W'(cell_full - (CELL_W+1)'(1));

    assign tx_take  = run & ref_tick & (cell_cnt == '0);
    assign pulse_on = (pulse_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cell_cnt  <= '0;
            pulse_cnt <= '0;
        end else if (tx_take) begin
            cell_cnt  <= cell_last;
            pulse_cnt <= tx_bit ? '0 : pulse_len;
        end else begin
            if (ref_tick) cell_cnt <= cell_cnt - CELL_W'(1);
            if (unit_tick && pulse_on) pulse_cnt <= pulse_cnt - PULSE_W'(1);
        end
    end

endmodule

// File: rtl/ir_phy_stager.sv
module ir_phy_stager
    import irst_pkg::*;
#(
    parameter int BAUD_W   = 6,
    parameter int WID_W    = 5,
    parameter int PRE_W    = 5,
    parameter int CELL_SUB = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [CFG_W-1:0]                  cfg_wdata,
    input  logic                              phy_we,
    input  logic [BAUD_W+WID_W+PRE_W-1:0]     phy_wdata,
    input  logic                              phy_en,
    input  logic                              ref_tick,
    input  logic                              unit_tick,
    input  logic                              tx_bit,
    output logic                              tx_take,
    output logic                              ir_tx,
    input  logic                              ir_rx,
    output logic                              rx_data,
    output logic [STAT_W-1:0]                 status,
    output logic [BAUD_W+WID_W+PRE_W-1:0]     phy_act
);

    localparam int PHY_W    = BAUD_W + WID_W + PRE_W;
    localparam int WID_LSB  = PRE_W;
    localparam int BAUD_LSB = PRE_W + WID_W;

    logic        en_q;
    ir_applied_t act;
    ir_cfg_t     live_cfg;
    logic        run;
    logic        pulse_on;

    ir_cfg_stage #(.PHY_W(PHY_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_d    (ir_cfg_t'(cfg_wdata)),
        .phy_we   (phy_we),
        .phy_d    (phy_wdata),
        .phy_en   (phy_en),
        .en_q     (en_q),
        .act      (act),
        .act_phy  (phy_act),
        .live_cfg (live_cfg)
    );

    assign run = en_q & act.sir & ~act.err;

    ir_sir_shaper #(
        .BAUD_W   (BAUD_W),
        .WID_W    (WID_W),
        .CELL_SUB (CELL_SUB)
    ) u_shape (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .ref_tick  (ref_tick),
        .unit_tick (unit_tick),
        .baud      (phy_act[BAUD_LSB +: BAUD_W]),
        .width     (phy_act[WID_LSB +: WID_W]),
        .tx_bit    (tx_bit),
        .tx_take   (tx_take),
        .pulse_on  (pulse_on)
    );

    assign ir_tx   = en_q & (pulse_on ^ act.tx_inv);
    assign rx_data = ir_rx ^ act.rx_inv;
    assign status  = pack_status(en_q, act, live_cfg);

endmodule

// File: rtl/ir_phy_stager_chk.sv
module ir_phy_stager_chk #(
    parameter int PHY_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             phy_en,
    input logic             ref_tick,
    input logic             tx_take,
    input logic             ir_tx,
    input logic [15:0]      status,
    input logic [PHY_W-1:0] phy_act
);

    a_r1_phy_hold: assert property (@(posedge clk) disable iff (rst)
        !$rose(phy_en) |=> $stable(phy_act));

    a_r3_err_clears_modes: assert property (@(posedge clk) disable iff (rst)
        status[14] |-> (status[13:11] == 3'b000));

    a_r4_single_mode: assert property (@(posedge clk) disable iff (rst)
        $onehot0(status[13:11]));

    a_r7_take_on_tick: assert property (@(posedge clk) disable iff (rst)
        tx_take |-> (ref_tick && status[11]));

    a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
        !status[15] |-> !ir_tx);

endmodule

bind ir_phy_stager ir_phy_stager_chk #(.PHY_W(PHY_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .phy_en   (phy_en),
    .ref_tick (ref_tick),
    .tx_take  (tx_take),
    .ir_tx    (ir_tx),
    .status   (status),
    .phy_act  (phy_act)
);

// File: tb/sim_ir_phy_stager.sv
module sim_ir_phy_stager;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [8:0]  cfg_wdata = '0;
    logic        phy_we = 1'b0;
    logic [15:0] phy_wdata = '0;
    logic        phy_en = 1'b0;
    logic        ref_tick = 1'b0;
    logic        unit_tick = 1'b0;
    logic        tx_bit = 1'b1;
    logic        ir_rx = 1'b0;
    logic        tx_take;
    logic        ir_tx;
    logic        rx_data;
    logic [15:0] status;
    logic [15:0] phy_act;

    always #5 clk = ~clk;

    ir_phy_stager u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .phy_we(phy_we), .phy_wdata(phy_wdata), .phy_en(phy_en),
        .ref_tick(ref_tick), .unit_tick(unit_tick), .tx_bit(tx_bit),
        .tx_take(tx_take), .ir_tx(ir_tx), .ir_rx(ir_rx), .rx_data(rx_data),
        .status(status), .phy_act(phy_act)
    );

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    string phase = "R10";

    // Reference model state
    logic [8:0]  m_stg = '0;
    logic [15:0] m_sphy = '0;
    logic        m_en = 0, m_sir = 0, m_mir = 0, m_fir = 0, m_crc = 0;
    logic        m_tinv = 0, m_rinv = 0, m_err = 0;
    logic [15:0] m_phy = '0;
    int          m_cell = 0, m_pulse = 0, m_idx = 0;
    logic [15:0] pattern = 16'b0110_1001_1100_0101;

    function automatic int dv(); return int'(m_phy[15:10]); endfunction
    function automatic int wd(); return int'(m_phy[9:5]); endfunction
    function automatic logic m_run(); return m_en & m_sir & ~m_err; endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stg = '0; m_sphy = '0; m_en = 0; m_sir = 0; m_mir = 0; m_fir = 0;
            m_crc = 0; m_tinv = 0; m_rinv = 0; m_err = 0; m_phy = '0;
            m_cell = 0; m_pulse = 0; m_idx = 0;
        end else begin
            logic rise;
            rise = phy_en & ~m_en;
            if (!m_run()) begin
                m_cell = 0; m_pulse = 0;
            end else if (ref_tick && m_cell == 0) begin
                m_pulse = tx_bit ? 0 : (wd() + 1) * (dv() + 1);
                m_cell = 16 * (dv() + 1) - 1;
                m_idx++;
            end else begin
                if (ref_tick) m_cell--;
                if (unit_tick && m_pulse > 0) m_pulse--;
            end
            if (rise) begin
                m_sir = m_stg[0]; m_mir = m_stg[1]; m_fir = m_stg[2];
                m_crc = m_stg[3]; m_tinv = m_stg[4]; m_rinv = m_stg[5];
                m_err = (int'(m_stg[0]) + int'(m_stg[1]) + int'(m_stg[2])) > 1;
                m_phy = m_sphy;
            end
            m_en = phy_en;
            if (cfg_we) m_stg = cfg_wdata;
            if (phy_we) m_sphy = phy_wdata;
        end
    end

    task automatic cmp(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) cycle %0d: actual %h expected %h", req, phase, ncyc, act, exp);
        end
    endtask

    task automatic compare_all();
        logic on;
        logic [15:0] es;
        on = m_en & ~m_err;
        es = {m_en, m_err, on & m_fir, on & m_mir, on & m_sir, m_stg[6],
              m_stg[7] & (~m_stg[6] | m_stg[8]), m_en & m_crc, 8'h00};
        cmp("R4 status", status, es);
        cmp("R2 phy_act", phy_act, m_phy);
        cmp("R6 ir_tx", 16'(ir_tx), 16'(m_en & ((m_pulse != 0) ^ m_tinv)));
        cmp("R7 tx_take", 16'(tx_take), 16'(m_run() & ref_tick & (m_cell == 0)));
        cmp("R9 rx_data", 16'(rx_data), 16'(ir_rx ^ m_rinv));
    endtask

    // One clock: compare at the falling edge, then drive the next inputs.
    task automatic cyc();
        @(negedge clk);
        ncyc++;
        compare_all();
        cfg_we = 0; phy_we = 0;
        ref_tick  = (ncyc % 7) == 0;
        unit_tick = (ncyc % 2) == 0;
        ir_rx     = ncyc[3];
        tx_bit    = pattern[m_idx % 16];
    endtask

    task automatic run_n(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_cfg(logic [8:0] v);
        cyc(); cfg_we = 1; cfg_wdata = v;
    endtask

    task automatic wr_phy(logic [15:0] v);
        cyc(); phy_we = 1; phy_wdata = v;
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        run_n(3);
        rst = 0;
        // R10: reset state on all outputs
        phase = "R10";
        cyc();
        cmp("R10 status", status, 16'h0000);
        cmp("R10 phy_act", phy_act, 16'h0000);
        // R1/R5: staging with enable low, receive/transmit enable status
        phase = "R5";
        wr_cfg(9'h089);            // low-speed, short CRC, rx_en
        wr_phy(16'h0062);          // D=0, W=3, preamble 2
        run_n(4);
        cmp("R5 rxst only rx", 16'(status[9]), 16'd1);
        cmp("R1 not applied", phy_act, 16'h0000);
        wr_cfg(9'h0C9);            // add tx_en
        run_n(3);
        cmp("R5 rxst blocked", 16'(status[9]), 16'd0);
        wr_cfg(9'h1C9);            // add loopback
        run_n(3);
        cmp("R5 rxst loop", 16'(status[9]), 16'd1);
        // R1/R6/R7: apply, then run cells with D=0
        phase = "R6";
        cyc(); phy_en = 1;
        cyc();
        cmp("R1 applied phy", phy_act, 16'h0062);
        cmp("R4 sir on", status[15:8], 8'b1000_1111);
        run_n(1800);
        // R1: staged changes while enabled do not apply
        phase = "R1";
        wr_phy(16'h0440);          // D=1, W=2
        wr_cfg(9'h1D9);            // add transmit inversion
        run_n(300);
        cmp("R1 hold phy", phy_act, 16'h0062);
        // R8: enable low forces ir_tx low
        phase = "R8";
        cyc(); phy_en = 0;
        run_n(20);
        cmp("R8 low when off", 16'(ir_tx), 16'd0);
        phase = "R7";
        cyc(); phy_en = 1;
        run_n(2700);
        phase = "R8";
        cyc(); phy_en = 0;
        run_n(20);
        cmp("R8 inverted but off", 16'(ir_tx), 16'd0);
        // Long pulse case: D=2, W=31
        phase = "R6";
        wr_cfg(9'h001);
        wr_phy(16'h0BEF);
        cyc(); phy_en = 1;
        run_n(2700);
        cyc(); phy_en = 0;
        // R3: conflicting mode, R9: receive inversion
        phase = "R3";
        wr_cfg(9'h023);
        run_n(3);
        cyc(); phy_en = 1;
        run_n(100);
        cmp("R3 error flag", status[15:11], 5'b11000);
        // High-speed mode: no pulses, no takes
        phase = "R9";
        cyc(); phy_en = 0;
        wr_cfg(9'h00C);
        run_n(3);
        cyc(); phy_en = 1;
        run_n(100);
        cmp("R4 fir on", status[15:8], 8'b1010_0001);
        finish_sim();
    end

endmodule